// File: doc/BRIEF.md
# Split Instruction/Data L1 Request Dispatcher

This block sits in front of the coherence controller of a level-one cache that is split into an instruction side and a data side. Each cycle it picks one message from three incoming queues: responses from the shared cache, requests forwarded by other agents, and requests from the local processor. It turns that message into an event code and a line-aligned target address for the controller. It also reports which shared-cache bank owns the target line.

For processor requests the block drives a lookup address to both cache arrays. From the hit, free-way and victim information they return, it chooses the event. A hit in the correct side gives the demand event. A line found in the opposite side must first be evicted from there. A miss into a full set first evicts the probed victim. A processor request whose line the controller reports as busy is parked in a small ordered wait buffer. Parked requests are replayed oldest first once a wakeup names their line.

Top module: `l1_req_dispatch`

## Requirements
- R1: Fixed priority: a valid response wins over a valid forwarded request, which wins over processor work. At most one queue pop is asserted per cycle, and only for the selected source.
- R2: Response kinds map to events as 0 data→9, 1 exclusive data→10, 2 ack→11, 3 writeback ack→12.
- R3: Forwarded kinds map as 0 invalidate→5, 1 exclusive read→6, 2 upgrade→6 (same as exclusive read), 3 shared read→7, 4 instruction read→8.
- R4: Processor kinds are 0 load, 1 fetch, 2 store, 3 atomic. A fetch consults the instruction side and the others consult the data side. A hit gives event 1 (load), 2 (fetch) or 3 (store and atomic alike) on the request line.
- R5: When the line misses in the consulted side but is present in the other side, the block gives event 4 (replace) on the request line and does not pop the request.
- R6: On a miss in both sides, a free way in the consulted side gives the demand event. With no free way, the block gives event 4 on the victim line of that side and does not pop the request.
- R7: A response, a forwarded request or a demand event pops its source only in a cycle where `disp_valid` and `disp_ready` are both high.
- R8: `disp_line` has its low OFFS_W bits cleared. `disp_bank` equals `disp_line[OFFS_W +: BANK_W]`.
- R9: A processor request whose lookup reports busy is parked: it is popped with no dispatch. A later request to another line still dispatches. Reset empties the buffer.
- R10: A new processor request for a line that already has a parked entry is parked as well, even when the line is not busy.
- R11: A wakeup marks every parked entry of its line as ready. Ready entries replay oldest first, ahead of new processor requests, and each presents its line on `lk_addr`.
- R12: With the wait buffer full, a busy processor request is neither popped nor dispatched.
- R13: A line is never reported present in both sides at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsp_valid | input | 1 | Response queue head valid |
| rsp_kind | input | 2 | Response kind |
| rsp_addr | input | ADDR_W | Response address |
| rsp_pop | output | 1 | Consume response head |
| fwd_valid | input | 1 | Forwarded queue head valid |
| fwd_kind | input | 3 | Forwarded kind |
| fwd_addr | input | ADDR_W | Forwarded address |
| fwd_pop | output | 1 | Consume forwarded head |
| cpu_valid | input | 1 | Processor queue head valid |
| cpu_kind | input | 2 | Processor request kind |
| cpu_addr | input | ADDR_W | Processor request address |
| cpu_pop | output | 1 | Consume processor head |
| lk_addr | output | ADDR_W | Line address looked up in both sides |
| lk_ihit | input | 1 | Line present in instruction side |
| lk_dhit | input | 1 | Line present in data side |
| lk_iavail | input | 1 | Free way in instruction set |
| lk_davail | input | 1 | Free way in data set |
| lk_ivictim | input | ADDR_W | Instruction-side victim line |
| lk_dvictim | input | ADDR_W | Data-side victim line |
| lk_busy | input | 1 | Controller has the line in a transient state |
| wake_valid | input | 1 | Wakeup strobe |
| wake_addr | input | ADDR_W | Line being woken |
| disp_valid | output | 1 | Event offered to controller |
| disp_event | output | 4 | Event code |
| disp_line | output | ADDR_W | Target line address |
| disp_bank | output | BANK_W | Shared-cache bank of the target |
| disp_ready | input | 1 | Controller consumes the event |

## Verification
The checker takes for granted that the cache arrays never report a lookup line as present in both sides, and that the queue kind fields carry only the listed codes. It also assumes victim addresses arrive line-aligned. The stimulus keeps to all of this: it never raises both hit flags together, it drives only defined kinds, and its victim addresses have clear offset bits. Parking and replay are driven through sequences where wakeups arrive only while no processor request could race with them.

// File: rtl/l1d_pkg.sv
package l1d_pkg;

    typedef enum logic [1:0] {
        CPU_LOAD   = 2'd0,
        CPU_IFETCH = 2'd1,
        CPU_STORE  = 2'd2,
        CPU_ATOMIC = 2'd3
    } cpu_op_e;

    typedef enum logic [3:0] {
        EV_NONE      = 4'd0,
        EV_LOAD      = 4'd1,
        EV_IFETCH    = 4'd2,
        EV_STORE     = 4'd3,
        EV_REPL      = 4'd4,
        EV_INV       = 4'd5,
        EV_FWD_EXCL  = 4'd6,
        EV_FWD_SHR   = 4'd7,
        EV_FWD_INSTR = 4'd8,
        EV_DATA      = 4'd9,
        EV_DATA_EXCL = 4'd10,
        EV_ACK       = 4'd11,
        EV_WB_ACK    = 4'd12
    } ev_e;

    function automatic ev_e rsp_to_event(logic [1:0] kind);
        case (kind)
            2'd0:    return EV_DATA;
            2'd1:    return EV_DATA_EXCL;
            2'd2:    return EV_ACK;
            default: return EV_WB_ACK;
        endcase
    endfunction

    function automatic ev_e fwd_to_event(logic [2:0] kind);
        case (kind)
            3'd0:       return EV_INV;
            3'd1, 3'd2: return EV_FWD_EXCL;
            3'd3:       return EV_FWD_SHR;
            3'd4:       return EV_FWD_INSTR;
            default:    return EV_NONE;
        endcase
    endfunction

    function automatic ev_e demand_event(cpu_op_e op);
        case (op)
            CPU_LOAD:   return EV_LOAD;
            CPU_IFETCH: return EV_IFETCH;
            default:    return EV_STORE;
        endcase
    endfunction

endpackage

// File: rtl/l1d_prio_arb.sv
module l1d_prio_arb #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_lane
            if (i == 0) begin : g_top
                assign gnt[i] = req[i];
            end else begin : g_low
                assign gnt[i] = req[i] & ~(|req[i-1:0]);
            end
        end
    endgenerate
endmodule

// File: rtl/l1d_cpu_classify.sv
module l1d_cpu_classify
    import l1d_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  cpu_op_e          op,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             ihit,
    input  logic             dhit,
    input  logic             iavail,
    input  logic             davail,
    input  logic [TAG_W-1:0] ivic_tag,
    input  logic [TAG_W-1:0] dvic_tag,
    output ev_e              ev,
    output logic [TAG_W-1:0] tgt_tag,
    output logic             demand
);
    logic is_fetch, own_hit, other_hit, own_free;
    logic [TAG_W-1:0] own_vic;

    always_comb begin
        is_fetch  = (op == CPU_IFETCH);
        own_hit   = is_fetch ? ihit : dhit;
        other_hit = is_fetch ? dhit : ihit;
        own_free  = is_fetch ? iavail : davail;
        own_vic   = is_fetch ? ivic_tag : dvic_tag;

        if (own_hit) begin
            ev = demand_event(op); tgt_tag = req_tag; demand = 1'b1;
        end else if (other_hit) begin
            ev = EV_REPL; tgt_tag = req_tag; demand = 1'b0;
        end else if (own_free) begin
            ev = demand_event(op); tgt_tag = req_tag; demand = 1'b1;
        end else begin
            ev = EV_REPL; tgt_tag = own_vic; demand = 1'b0;
        end
    end
endmodule

// File: rtl/l1d_wait_buf.sv
module l1d_wait_buf
    import l1d_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int TAG_W = 12,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    input  cpu_op_e          push_op,
    input  logic             remove,
    input  logic             unready,
    input  logic             wake,
    input  logic [TAG_W-1:0] wake_tag,
    input  logic [TAG_W-1:0] probe_tag,
    output logic             probe_hit,
    output logic             head_valid,
    output logic [TAG_W-1:0] head_tag,
    output cpu_op_e          head_op,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    logic [DEPTH-1:0] vld_q, rdy_q, vld_d, rdy_d;
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [TAG_W-1:0] tag_d [DEPTH];
    cpu_op_e          op_q  [DEPTH];
    cpu_op_e          op_d  [DEPTH];
    logic [IDX_W-1:0] sel;

    always_comb begin
        head_valid = 1'b0;
        sel        = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vld_q[i] && rdy_q[i]) begin
                head_valid = 1'b1;
                sel        = IDX_W'(i);
            end
        end
        head_tag  = tag_q[sel];
        head_op   = op_q[sel];
        count     = CNT_W'($countones(vld_q));
        full      = vld_q[DEPTH-1];
        probe_hit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (vld_q[i] && (tag_q[i] == probe_tag)) probe_hit = 1'b1;
        end
    end

    always_comb begin
        vld_d = vld_q;
        rdy_d = rdy_q;
        tag_d = tag_q;
        op_d  = op_q;
        if (remove) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (i >= int'(sel)) begin
                    vld_d[i] = vld_q[i+1];
                    rdy_d[i] = rdy_q[i+1];
                    tag_d[i] = tag_q[i+1];
                    op_d[i]  = op_q[i+1];
                end
            end
            vld_d[DEPTH-1] = 1'b0;
            rdy_d[DEPTH-1] = 1'b0;
        end
        if (unready) rdy_d[sel] = 1'b0;
        if (push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (int'(count) == i) begin
                    vld_d[i] = 1'b1;
                    rdy_d[i] = 1'b0;
                    tag_d[i] = push_tag;
                    op_d[i]  = push_op;
                end
            end
        end
        if (wake) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (vld_d[i] && (tag_d[i] == wake_tag)) rdy_d[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            rdy_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                tag_q[i] <= '0;
                op_q[i]  <= CPU_LOAD;
            end
        end else begin
            vld_q <= vld_d;
            rdy_q <= rdy_d;
            tag_q <= tag_d;
            op_q  <= op_d;
        end
    end
endmodule

// File: rtl/l1_req_dispatch.sv
module l1_req_dispatch
    import l1d_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int OFFS_W     = 4,
    parameter int BANK_W     = 2,
    parameter int WAIT_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rsp_valid,
    input  logic [1:0]        rsp_kind,
    input  logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_pop,
    input  logic              fwd_valid,
    input  logic [2:0]        fwd_kind,
    input  logic [ADDR_W-1:0] fwd_addr,
    output logic              fwd_pop,
    input  logic              cpu_valid,
    input  logic [1:0]        cpu_kind,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_pop,
    output logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_ihit,
    input  logic              lk_dhit,
    input  logic              lk_iavail,
    input  logic              lk_davail,
    input  logic [ADDR_W-1:0] lk_ivictim,
    input  logic [ADDR_W-1:0] lk_dvictim,
    input  logic              lk_busy,
    input  logic              wake_valid,
    input  logic [ADDR_W-1:0] wake_addr,
    output logic              disp_valid,
    output logic [3:0]        disp_event,
    output logic [ADDR_W-1:0] disp_line,
    output logic [BANK_W-1:0] disp_bank,
    input  logic              disp_ready
);
    localparam int TAG_W = ADDR_W - OFFS_W;
    localparam int CNT_W = $clog2(WAIT_DEPTH + 1);

    logic [TAG_W-1:0] cand_tag, cls_tag, out_tag, head_tag;
    cpu_op_e          cand_op, head_op;
    ev_e              cls_ev;
    logic             cls_demand, head_valid, probe_hit, wb_full;
    logic             wb_push, wb_remove, wb_unready, cand_valid, hold;
    logic [2:0]       req_vec, gnt_vec;
    logic [CNT_W-1:0] wait_cnt;

    assign cand_valid = head_valid | cpu_valid;
    assign cand_tag   = head_valid ? head_tag : cpu_addr[ADDR_W-1:OFFS_W];
    assign cand_op    = head_valid ? head_op  : cpu_op_e'(cpu_kind);
    assign lk_addr    = {cand_tag, {OFFS_W{1'b0}}};
    assign req_vec    = {cand_valid, fwd_valid, rsp_valid};

    l1d_prio_arb #(.N(3)) u_arb (
        .req (req_vec),
        .gnt (gnt_vec)
    );

    l1d_cpu_classify #(.TAG_W(TAG_W)) u_cls (
        .op       (cand_op),
        .req_tag  (cand_tag),
        .ihit     (lk_ihit),
        .dhit     (lk_dhit),
        .iavail   (lk_iavail),
        .davail   (lk_davail),
        .ivic_tag (lk_ivictim[ADDR_W-1:OFFS_W]),
        .dvic_tag (lk_dvictim[ADDR_W-1:OFFS_W]),
        .ev       (cls_ev),
        .tgt_tag  (cls_tag),
        .demand   (cls_demand)
    );

    l1d_wait_buf #(.DEPTH(WAIT_DEPTH), .TAG_W(TAG_W)) u_wb (
        .clk        (clk),
        .rst        (rst),
        .push       (wb_push),
        .push_tag   (cpu_addr[ADDR_W-1:OFFS_W]),
        .push_op    (cpu_op_e'(cpu_kind)),
        .remove     (wb_remove),
        .unready    (wb_unready),
        .wake       (wake_valid),
        .wake_tag   (wake_addr[ADDR_W-1:OFFS_W]),
        .probe_tag  (cpu_addr[ADDR_W-1:OFFS_W]),
        .probe_hit  (probe_hit),
        .head_valid (head_valid),
        .head_tag   (head_tag),
        .head_op    (head_op),
        .full       (wb_full),
        .count      (wait_cnt)
    );

    always_comb begin
        disp_valid = 1'b0;
        disp_event = EV_NONE;
        out_tag    = '0;
        rsp_pop    = 1'b0;
        fwd_pop    = 1'b0;
        cpu_pop    = 1'b0;
        wb_push    = 1'b0;
        wb_remove  = 1'b0;
        wb_unready = 1'b0;
        hold       = lk_busy | (~head_valid & probe_hit);
        if (gnt_vec[0]) begin
            disp_valid = 1'b1;
            disp_event = rsp_to_event(rsp_kind);
            out_tag    = rsp_addr[ADDR_W-1:OFFS_W];
            rsp_pop    = disp_ready;
        end else if (gnt_vec[1]) begin
            disp_valid = 1'b1;
            disp_event = fwd_to_event(fwd_kind);
            out_tag    = fwd_addr[ADDR_W-1:OFFS_W];
            fwd_pop    = disp_ready;
        end else if (gnt_vec[2]) begin
            if (hold) begin
                if (head_valid) begin
                    wb_unready = 1'b1;
                end else if (!wb_full) begin
                    wb_push = 1'b1;
                    cpu_pop = 1'b1;
                end
            end else begin
                disp_valid = 1'b1;
                disp_event = cls_ev;
                out_tag    = cls_tag;
                if (disp_ready && cls_demand) begin
                    if (head_valid) wb_remove = 1'b1;
                    else            cpu_pop   = 1'b1;
                end
            end
        end
    end

    assign disp_line = {out_tag, {OFFS_W{1'b0}}};
    assign disp_bank = disp_line[OFFS_W +: BANK_W];

endmodule

// File: rtl/l1d_dispatch_chk.sv
module l1d_dispatch_chk #(
    parameter int ADDR_W = 16,
    parameter int OFFS_W = 4,
    parameter int DEPTH  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              rsp_valid,
    input logic              rsp_pop,
    input logic              fwd_pop,
    input logic              cpu_pop,
    input logic              lk_ihit,
    input logic              lk_dhit,
    input logic              disp_valid,
    input logic              disp_ready,
    input logic [3:0]        disp_event,
    input logic [ADDR_W-1:0] disp_line,
    input logic [CNT_W-1:0]  wait_cnt
);
    a_r1_one_pop: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_pop, fwd_pop, cpu_pop}));

    a_r1_rsp_first: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (!fwd_pop && !cpu_pop));

    a_r7_pop_handshake: assert property (@(posedge clk) disable iff (rst)
        (rsp_pop || fwd_pop) |-> (disp_valid && disp_ready));

    a_r5_repl_keeps_req: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_event == 4'd4) |-> !cpu_pop);

    a_r8_line_aligned: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> (disp_line[OFFS_W-1:0] == '0));

    a_r9_park_grows: assert property (@(posedge clk) disable iff (rst)
        (cpu_pop && !disp_valid) |=> (wait_cnt == $past(wait_cnt) + 1'b1));

    a_r12_bounded: assert property (@(posedge clk) disable iff (rst)
        wait_cnt <= CNT_W'(DEPTH));

    a_r13_single_side: assert property (@(posedge clk) disable iff (rst)
        !(lk_ihit && lk_dhit));
endmodule

bind l1_req_dispatch l1d_dispatch_chk #(
    .ADDR_W (ADDR_W),
    .OFFS_W (OFFS_W),
    .DEPTH  (WAIT_DEPTH)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rsp_valid  (rsp_valid),
    .rsp_pop    (rsp_pop),
    .fwd_pop    (fwd_pop),
    .cpu_pop    (cpu_pop),
    .lk_ihit    (lk_ihit),
    .lk_dhit    (lk_dhit),
    .disp_valid (disp_valid),
    .disp_ready (disp_ready),
    .disp_event (disp_event),
    .disp_line  (disp_line),
    .wait_cnt   (wait_cnt)
);

// File: tb/l1_req_dispatch_tb.sv
module l1_req_dispatch_tb;
    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst;
    logic rsp_valid, fwd_valid, cpu_valid;
    logic [1:0] rsp_kind, cpu_kind;
    logic [2:0] fwd_kind;
    logic [AW-1:0] rsp_addr, fwd_addr, cpu_addr, lk_addr, lk_ivictim, lk_dvictim, wake_addr, disp_line;
    logic rsp_pop, fwd_pop, cpu_pop;
    logic lk_ihit, lk_dhit, lk_iavail, lk_davail, lk_busy, wake_valid;
    logic disp_valid, disp_ready;
    logic [3:0] disp_event;
    logic [1:0] disp_bank;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    l1_req_dispatch u_dut (
        .clk(clk), .rst(rst),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_addr(rsp_addr), .rsp_pop(rsp_pop),
        .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .fwd_addr(fwd_addr), .fwd_pop(fwd_pop),
        .cpu_valid(cpu_valid), .cpu_kind(cpu_kind), .cpu_addr(cpu_addr), .cpu_pop(cpu_pop),
        .lk_addr(lk_addr), .lk_ihit(lk_ihit), .lk_dhit(lk_dhit),
        .lk_iavail(lk_iavail), .lk_davail(lk_davail),
        .lk_ivictim(lk_ivictim), .lk_dvictim(lk_dvictim), .lk_busy(lk_busy),
        .wake_valid(wake_valid), .wake_addr(wake_addr),
        .disp_valid(disp_valid), .disp_event(disp_event), .disp_line(disp_line),
        .disp_bank(disp_bank), .disp_ready(disp_ready)
    );

    typedef struct packed {
        logic       rv; logic [1:0] rk;
        logic       fv; logic [2:0] fk;
        logic       cv; logic [1:0] ck;
        logic       ih; logic dh; logic ia; logic da;
        logic [3:0] ev; logic xv; logic [2:0] ls; logic [2:0] pops;
    } vec_t;

    // line select: 0 rsp, 1 fwd, 2 cpu, 3 ivictim, 4 dvictim; pops = {cpu,fwd,rsp}
    localparam vec_t TBL [18] = '{
        '{1'b1,2'd0,1'b1,3'd1,1'b1,2'd0,1'b0,1'b1,1'b1,1'b1,4'd9 ,1'b1,3'd0,3'b001}, // R1 R2
        '{1'b1,2'd3,1'b0,3'd0,1'b0,2'd0,1'b0,1'b0,1'b1,1'b1,4'd12,1'b1,3'd0,3'b001}, // R2
        '{1'b1,2'd1,1'b0,3'd0,1'b1,2'd0,1'b0,1'b1,1'b1,1'b1,4'd10,1'b1,3'd0,3'b001}, // R2
        '{1'b0,2'd0,1'b1,3'd2,1'b1,2'd0,1'b0,1'b1,1'b1,1'b1,4'd6 ,1'b1,3'd1,3'b010}, // R3 upgrade
        '{1'b0,2'd0,1'b1,3'd1,1'b0,2'd0,1'b0,1'b0,1'b1,1'b1,4'd6 ,1'b1,3'd1,3'b010}, // R3
        '{1'b0,2'd0,1'b1,3'd3,1'b0,2'd0,1'b0,1'b0,1'b1,1'b1,4'd7 ,1'b1,3'd1,3'b010}, // R3
        '{1'b0,2'd0,1'b1,3'd4,1'b0,2'd0,1'b0,1'b0,1'b1,1'b1,4'd8 ,1'b1,3'd1,3'b010}, // R3
        '{1'b0,2'd0,1'b1,3'd0,1'b0,2'd0,1'b0,1'b0,1'b1,1'b1,4'd5 ,1'b1,3'd1,3'b010}, // R3
        '{1'b0,2'd0,1'b0,3'd0,1'b1,2'd0,1'b0,1'b1,1'b1,1'b1,4'd1 ,1'b1,3'd2,3'b100}, // R4
        '{1'b0,2'd0,1'b0,3'd0,1'b1,2'd1,1'b1,1'b0,1'b1,1'b1,4'd2 ,1'b1,3'd2,3'b100}, // R4
        '{1'b0,2'd0,1'b0,3'd0,1'b1,2'd3,1'b0,1'b1,1'b1,1'b1,4'd3 ,1'b1,3'd2,3'b100}, // R4
        '{1'b0,2'd0,1'b0,3'd0,1'b1,2'd2,1'b1,1'b0,1'b1,1'b1,4'd4 ,1'b1,3'd2,3'b000}, // R5
        '{1'b0,2'd0,1'b0,3'd0,1'b1,2'd1,1'b0,1'b1,1'b1,1'b1,4'd4 ,1'b1,3'd2,3'b000}, // R5
        '{1'b0,2'd0,1'b0,3'd0,1'b1,2'd0,1'b0,1'b0,1'b0,1'b1,4'd1 ,1'b1,3'd2,3'b100}, // R6
        '{1'b0,2'd0,1'b0,3'd0,1'b1,2'd2,1'b0,1'b0,1'b1,1'b0,4'd4 ,1'b1,3'd4,3'b000}, // R6
        '{1'b0,2'd0,1'b0,3'd0,1'b1,2'd1,1'b0,1'b0,1'b0,1'b1,4'd4 ,1'b1,3'd3,3'b000}, // R6
        '{1'b0,2'd0,1'b0,3'd0,1'b0,2'd0,1'b0,1'b0,1'b1,1'b1,4'd0 ,1'b0,3'd0,3'b000}, // R1 idle
        '{1'b0,2'd0,1'b0,3'd0,1'b1,2'd1,1'b0,1'b0,1'b1,1'b0,4'd2 ,1'b1,3'd2,3'b100}  // R6
    };

    function automatic string vec_req(int i);
        if (i < 3)  return "R2";
        if (i < 8)  return "R3";
        if (i < 11) return "R4";
        if (i < 13) return "R5";
        if (i == 16) return "R1";
        return "R6";
    endfunction

    function automatic logic [AW-1:0] sel_line(logic [2:0] s);
        case (s)
            3'd0: return 16'h1230;
            3'd1: return 16'h4560;
            3'd2: return 16'h7890;
            3'd3: return 16'hA000;
            default: return 16'hB010;
        endcase
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rsp_valid = 0; fwd_valid = 0; cpu_valid = 0;
        rsp_kind = 0; fwd_kind = 0; cpu_kind = 0;
        lk_ihit = 0; lk_dhit = 0; lk_iavail = 1; lk_davail = 1;
        lk_busy = 0; wake_valid = 0; wake_addr = '0; disp_ready = 1;
    endtask

    task automatic cpu_req(logic [1:0] k, logic [AW-1:0] a, logic busy, logic dh);
        @(negedge clk);
        idle_inputs();
        cpu_valid = 1; cpu_kind = k; cpu_addr = a; lk_busy = busy; lk_dhit = dh;
        #2;
    endtask

    task automatic expect_out(string req, logic v, logic [3:0] ev, logic [AW-1:0] ln, logic cp);
        check(req, "disp_valid", 32'(disp_valid), 32'(v));
        if (v) begin
            check(req, "disp_event", 32'(disp_event), 32'(ev));
            check(req, "disp_line", 32'(disp_line), 32'(ln));
        end
        check(req, "cpu_pop", 32'(cpu_pop), 32'(cp));
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rsp_addr = 16'h1234; fwd_addr = 16'h4567; cpu_addr = 16'h789A;
        lk_ivictim = 16'hA000; lk_dvictim = 16'hB010;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #2;
        // reset state (R1)
        check("R1", "reset disp_valid", 32'(disp_valid), 0);
        check("R1", "reset pops", 32'({cpu_pop, fwd_pop, rsp_pop}), 0);

        // table walk
        for (int i = 0; i < 18; i++) begin
            @(negedge clk);
            idle_inputs();
            cpu_addr = 16'h789A;
            rsp_valid = TBL[i].rv; rsp_kind = TBL[i].rk;
            fwd_valid = TBL[i].fv; fwd_kind = TBL[i].fk;
            cpu_valid = TBL[i].cv; cpu_kind = TBL[i].ck;
            lk_ihit = TBL[i].ih; lk_dhit = TBL[i].dh;
            lk_iavail = TBL[i].ia; lk_davail = TBL[i].da;
            #2;
            check(vec_req(i), "disp_valid", 32'(disp_valid), 32'(TBL[i].xv));
            check("R1", "pops", 32'({cpu_pop, fwd_pop, rsp_pop}), 32'(TBL[i].pops));
            if (TBL[i].xv) begin
                check(vec_req(i), "disp_event", 32'(disp_event), 32'(TBL[i].ev));
                check(vec_req(i), "disp_line", 32'(disp_line), 32'(sel_line(TBL[i].ls)));
                check("R8", "disp_bank", 32'(disp_bank), 32'(sel_line(TBL[i].ls) >> 4) & 3);
            end
        end

        // R7: no pop without ready
        @(negedge clk);
        idle_inputs();
        rsp_valid = 1; rsp_kind = 2; disp_ready = 0;
        #2;
        check("R7", "rsp_pop no ready", 32'(rsp_pop), 0);
        check("R2", "ack event", 32'(disp_event), 11);
        cpu_req(2'd0, 16'h2220, 0, 1);
        disp_ready = 0; #1;
        check("R7", "cpu_pop no ready", 32'(cpu_pop), 0);

        // R9 park, R10 same-line park, R11 ordered replay
        cpu_req(2'd0, 16'h3000, 1, 1);
        expect_out("R9", 0, 0, 0, 1);
        cpu_req(2'd0, 16'h5010, 0, 1);
        expect_out("R9", 1, 1, 16'h5010, 1);
        cpu_req(2'd2, 16'h3004, 0, 1);
        expect_out("R10", 0, 0, 0, 1);
        @(negedge clk); idle_inputs();
        wake_valid = 1; wake_addr = 16'h3000; #2;
        check("R11", "no dispatch during wake", 32'(disp_valid), 0);
        cpu_req(2'd0, 16'h6020, 0, 1);
        expect_out("R11", 1, 1, 16'h3000, 0);
        check("R11", "lk_addr replay", 32'(lk_addr), 32'h3000);
        cpu_req(2'd0, 16'h6020, 0, 1);
        expect_out("R11", 1, 3, 16'h3000, 0);
        cpu_req(2'd0, 16'h6020, 0, 1);
        expect_out("R11", 1, 1, 16'h6020, 1);
        @(negedge clk); idle_inputs(); #2;
        check("R11", "drained", 32'(disp_valid), 0);

        // R12 full buffer
        for (int k = 0; k < 4; k++) begin
            cpu_req(2'd0, 16'h7030, 1, 0);
            expect_out("R12", 0, 0, 0, 1);
        end
        cpu_req(2'd0, 16'h7030, 1, 0);
        expect_out("R12", 0, 0, 0, 0);
        @(negedge clk); idle_inputs(); wake_valid = 1; wake_addr = 16'h7030;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); idle_inputs(); lk_dhit = 1; #2;
            expect_out("R11", 1, 1, 16'h7030, 0);
            check("R8", "bank replay", 32'(disp_bank), 3);
        end
        @(negedge clk); idle_inputs(); #2;
        check("R12", "empty after drain", 32'(disp_valid), 0);

        // R9: reset clears parked entries
        cpu_req(2'd0, 16'h3000, 1, 0);
        expect_out("R9", 0, 0, 0, 1);
        @(negedge clk); idle_inputs(); rst = 1;
        @(negedge clk); rst = 0; wake_valid = 1; wake_addr = 16'h3000;
        @(negedge clk); idle_inputs(); lk_dhit = 1; #2;
        check("R9", "reset empties buffer", 32'(disp_valid), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule